// File: doc/BRIEF.md
# Graphics Function Base Address Registers and Cycle Decoder

This block keeps the two base address registers of one graphics function in configuration space: a 32-bit memory register that places a fixed 512 KB window, and an I/O register that places a fixed 8-byte window in the 16-bit I/O space. Software programs them through a small configuration port that selects a register by dword index and writes under byte enables.

The same block watches CPU cycles and raises a one-cycle claim when a cycle falls inside one of the two windows and the gating conditions hold. Memory cycles are gated only by the memory-enable command bit. I/O cycles also need the function to be in the full-power state with the I/O-enable command bit set, and both the device and the internal graphics must be switched on.

Top module: `gbar_decode_top`

## Requirements
- R1: After reset the memory register reads 00000000h and the I/O register reads 00000001h.
- R2: The memory register is at dword index 5 (byte offset 14h). Only bits 31:19 take written data. Bits 18:0 always read zero: bit 3 non-prefetchable, bits 2:1 32-bit type, bit 0 memory space.
- R3: The I/O register is at dword index 6 (byte offset 18h). Only bits 15:3 take written data. Bits 31:16 and 2:1 read zero, and bit 0 always reads one.
- R4: Byte enable bit i (cfg_be[i]) gates data bits 8i+7:8i. A writable bit in a disabled byte keeps its value.
- R5: Read data shows up on cfg_rdata the cycle after cfg_rd_en and holds until the next read. Any other dword index reads zero, and writes to it change neither register.
- R6: A memory cycle (cpu_is_io=0) whose address bits 31:19 equal the programmed base, with mem_en=1, raises cpu_claim for exactly the following cycle.
- R7: An I/O cycle (cpu_is_io=1) with address bits 31:16 zero and bits 15:3 equal to the programmed base is claimed on the following cycle when pm_state=00 (D0), io_en=1, dev_off=0 and gfx_dis=0.
- R8: An I/O cycle is not claimed if pm_state is 01, 10 or 11 (D1 to D3), io_en=0, dev_off=1 or gfx_dis=1.
- R9: cpu_size 00 (byte), 01 (word) and 10 (dword) are claimed when they hit. A hit depends only on the lowest byte address, so an access that runs past the window end is still claimed. Code 11 is never claimed.
- R10: When a configuration write and a CPU cycle fall in the same cycle, the decode uses the base held before the write. The new base decides from the next cycle on.
- R11: With mem_en=0 no memory cycle is claimed. In particular, the zero base after reset does not claim address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dword | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after a read |
| cpu_valid | input | 1 | CPU cycle present |
| cpu_addr | input | 32 | CPU cycle byte address |
| cpu_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cpu_size | input | 2 | 00 byte, 01 word, 10 dword, 11 reserved |
| pm_state | input | 2 | Power state, 00 = D0 through 11 = D3 |
| io_en | input | 1 | I/O-enable command bit |
| mem_en | input | 1 | Memory-enable command bit |
| dev_off | input | 1 | Device switched off |
| gfx_dis | input | 1 | Internal graphics disabled |
| cpu_claim | output | 1 | Cycle claimed, one cycle after cpu_valid |

## Verification
A configuration write that moves a base and a CPU cycle aimed at that window can arrive in the same clock. The bench drives both on one edge, first with the cycle addressed to the new base and then with the old base. It expects no claim for the first case and a claim for the second, and then repeats the cycle at the new base alone, where it expects a claim. The outcome shows whether the decode reads the base before or after the write.

// File: rtl/gbar_pkg.sv
package gbar_pkg;

    typedef enum logic [1:0] {
        PWR_D0 = 2'b00,
        PWR_D1 = 2'b01,
        PWR_D2 = 2'b10,
        PWR_D3 = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        XFER_BYTE  = 2'b00,
        XFER_WORD  = 2'b01,
        XFER_DWORD = 2'b10,
        XFER_RSVD  = 2'b11
    } xfer_size_e;

    localparam int CFG_DATA_W = 32;
    localparam int CFG_BYTES  = CFG_DATA_W / 8;

endpackage

// File: rtl/gbar_cfg_regs.sv
module gbar_cfg_regs
    import gbar_pkg::*;
#(
    parameter int          MEM_WIN_LOG2 = 19,
    parameter int          IO_SPACE_W   = 16,
    parameter int          IO_WIN_LOG2  = 3,
    parameter logic [5:0]  MEM_DW_IDX   = 6'd5,
    parameter logic [5:0]  IO_DW_IDX    = 6'd6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic                               rd_en,
    input  logic [5:0]                         dword,
    input  logic [CFG_BYTES-1:0]               be,
    input  logic [CFG_DATA_W-1:0]              wdata,
    output logic [CFG_DATA_W-1:0]              rdata,
    output logic [CFG_DATA_W-1:MEM_WIN_LOG2]   mem_base,
    output logic [IO_SPACE_W-1:IO_WIN_LOG2]    io_base
);

    localparam logic [CFG_DATA_W-1:0] MEM_WMASK =
        {{(CFG_DATA_W-MEM_WIN_LOG2){1'b1}}, {MEM_WIN_LOG2{1'b0}}};
    localparam logic [CFG_DATA_W-1:0] IO_WMASK =
        {{(CFG_DATA_W-IO_SPACE_W){1'b0}}, {(IO_SPACE_W-IO_WIN_LOG2){1'b1}},
         {IO_WIN_LOG2{1'b0}}};
    localparam logic [CFG_DATA_W-1:0] IO_FIXED = {{(CFG_DATA_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CFG_DATA_W-1:0] mem;
        logic [CFG_DATA_W-1:0] io;
        logic [CFG_DATA_W-1:0] rdata;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [CFG_DATA_W-1:0] lane_mask;
    logic [CFG_DATA_W-1:0] mem_view, io_view;

    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{be[b]}};
    end

    assign mem_view = st_q.mem & MEM_WMASK;
    assign io_view  = (st_q.io & IO_WMASK) | IO_FIXED;

    always_comb begin
        st_d = st_q;
        if (wr_en && dword == MEM_DW_IDX) begin
            st_d.mem = (st_q.mem & ~(MEM_WMASK & lane_mask))
                     | (wdata & MEM_WMASK & lane_mask);
        end
        if (wr_en && dword == IO_DW_IDX) begin
            st_d.io = (st_q.io & ~(IO_WMASK & lane_mask))
                    | (wdata & IO_WMASK & lane_mask);
        end
        if (rd_en) begin
            if (dword == MEM_DW_IDX)     st_d.rdata = mem_view;
            else if (dword == IO_DW_IDX) st_d.rdata = io_view;
            else                         st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.rdata;
    assign mem_base = mem_view[CFG_DATA_W-1:MEM_WIN_LOG2];
    assign io_base  = io_view[IO_SPACE_W-1:IO_WIN_LOG2];

endmodule

// File: rtl/gbar_win_match.sv
module gbar_win_match #(
    parameter int ADDR_W   = 32,
    parameter int SPACE_W  = 16,
    parameter int WIN_LOG2 = 3
) (
    input  logic [ADDR_W-1:WIN_LOG2]  addr_hi,
    input  logic [SPACE_W-1:WIN_LOG2] base,
    output logic                      hit
);

    logic field_eq;
    logic above_zero;

    assign field_eq = (addr_hi[SPACE_W-1:WIN_LOG2] == base);

    if (SPACE_W < ADDR_W) begin : g_upper
        assign above_zero = (addr_hi[ADDR_W-1:SPACE_W] == '0);
    end else begin : g_full
        assign above_zero = 1'b1;
    end

    assign hit = field_eq && above_zero;

endmodule

// File: rtl/gbar_claim.sv
module gbar_claim
    import gbar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic       is_io,
    input  xfer_size_e size,
    input  logic       mem_hit,
    input  logic       io_hit,
    input  pwr_state_e pwr,
    input  logic       io_en,
    input  logic       mem_en,
    input  logic       dev_off,
    input  logic       gfx_dis,
    output logic       claim
);

    typedef struct packed {
        logic claim;
    } claim_state_t;

    claim_state_t st_d, st_q;
    logic io_allowed;
    logic size_ok;

    assign io_allowed = (pwr == PWR_D0) && io_en && !dev_off && !gfx_dis;
    assign size_ok    = (size != XFER_RSVD);

    always_comb begin
        st_d = st_q;
        st_d.claim = 1'b0;
        if (valid && size_ok) begin
            if (is_io) st_d.claim = io_hit && io_allowed;
            else       st_d.claim = mem_hit && mem_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign claim = st_q.claim;

endmodule

// File: rtl/gbar_decode_top.sv
module gbar_decode_top
    import gbar_pkg::*;
#(
    parameter int          MEM_WIN_LOG2 = 19,
    parameter int          IO_SPACE_W   = 16,
    parameter int          IO_WIN_LOG2  = 3,
    parameter logic [5:0]  MEM_DW_IDX   = 6'd5,
    parameter logic [5:0]  IO_DW_IDX    = 6'd6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic        cfg_rd_en,
    input  logic [5:0]  cfg_dword,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        cpu_valid,
    input  logic [31:0] cpu_addr,
    input  logic        cpu_is_io,
    input  logic [1:0]  cpu_size,
    input  logic [1:0]  pm_state,
    input  logic        io_en,
    input  logic        mem_en,
    input  logic        dev_off,
    input  logic        gfx_dis,
    output logic        cpu_claim
);

    localparam int ADDR_W = CFG_DATA_W;

    logic [ADDR_W-1:MEM_WIN_LOG2]   mem_base;
    logic [IO_SPACE_W-1:IO_WIN_LOG2] io_base;
    logic mem_hit, io_hit;
    logic unused_addr_bits;

    assign unused_addr_bits = ^cpu_addr[IO_WIN_LOG2-1:0];

    gbar_cfg_regs #(
        .MEM_WIN_LOG2 (MEM_WIN_LOG2),
        .IO_SPACE_W   (IO_SPACE_W),
        .IO_WIN_LOG2  (IO_WIN_LOG2),
        .MEM_DW_IDX   (MEM_DW_IDX),
        .IO_DW_IDX    (IO_DW_IDX)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .rd_en    (cfg_rd_en),
        .dword    (cfg_dword),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .mem_base (mem_base),
        .io_base  (io_base)
    );

    gbar_win_match #(
        .ADDR_W   (ADDR_W),
        .SPACE_W  (ADDR_W),
        .WIN_LOG2 (MEM_WIN_LOG2)
    ) mem_match_i (
        .addr_hi (cpu_addr[ADDR_W-1:MEM_WIN_LOG2]),
        .base    (mem_base),
        .hit     (mem_hit)
    );

    gbar_win_match #(
        .ADDR_W   (ADDR_W),
        .SPACE_W  (IO_SPACE_W),
        .WIN_LOG2 (IO_WIN_LOG2)
    ) io_match_i (
        .addr_hi (cpu_addr[ADDR_W-1:IO_WIN_LOG2]),
        .base    (io_base),
        .hit     (io_hit)
    );

    gbar_claim claim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cpu_valid),
        .is_io   (cpu_is_io),
        .size    (xfer_size_e'(cpu_size)),
        .mem_hit (mem_hit),
        .io_hit  (io_hit),
        .pwr     (pwr_state_e'(pm_state)),
        .io_en   (io_en),
        .mem_en  (mem_en),
        .dev_off (dev_off),
        .gfx_dis (gfx_dis),
        .claim   (cpu_claim)
    );

endmodule

// File: rtl/gbar_decode_chk.sv
module gbar_decode_chk #(
    parameter logic [5:0] MEM_DW_IDX = 6'd5,
    parameter logic [5:0] IO_DW_IDX  = 6'd6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_en,
    input logic [5:0]  cfg_dword,
    input logic [31:0] cfg_rdata,
    input logic        cpu_valid,
    input logic        cpu_is_io,
    input logic [1:0]  cpu_size,
    input logic [1:0]  pm_state,
    input logic        io_en,
    input logic        mem_en,
    input logic        dev_off,
    input logic        gfx_dis,
    input logic        cpu_claim
);

    AST_MEM_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd_en && cfg_dword == MEM_DW_IDX) |-> cfg_rdata[18:0] == 19'd0); // R2

    AST_IO_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd_en && cfg_dword == IO_DW_IDX) |-> (cfg_rdata[2:0] == 3'b001 && cfg_rdata[31:16] == 16'd0)); // R3

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_rd_en) |-> $stable(cfg_rdata)); // R5

    AST_CLAIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_claim |-> $past(cpu_valid)); // R6

    AST_MEM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_claim && !$past(cpu_is_io)) |-> $past(mem_en)); // R11

    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_claim && $past(cpu_is_io)) |-> $past(pm_state == 2'b00 && io_en && !dev_off && !gfx_dis)); // R8

    AST_NO_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_claim |-> $past(cpu_size) != 2'b11); // R9

endmodule

bind gbar_decode_top gbar_decode_chk #(
    .MEM_DW_IDX (MEM_DW_IDX),
    .IO_DW_IDX  (IO_DW_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rd_en (cfg_rd_en),
    .cfg_dword (cfg_dword),
    .cfg_rdata (cfg_rdata),
    .cpu_valid (cpu_valid),
    .cpu_is_io (cpu_is_io),
    .cpu_size  (cpu_size),
    .pm_state  (pm_state),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .dev_off   (dev_off),
    .gfx_dis   (gfx_dis),
    .cpu_claim (cpu_claim)
);

// File: tb/gbar_decode_top_tb_top.sv
`timescale 1ns/1ps
module gbar_decode_top_tb_top;

    localparam logic [5:0] MEM_IDX = 6'd5;
    localparam logic [5:0] IO_IDX  = 6'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [5:0]  cfg_dword = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_is_io = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [1:0]  pm_state = '0;
    logic        io_en = 1'b0, mem_en = 1'b0, dev_off = 1'b0, gfx_dis = 1'b0;
    logic        cpu_claim;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gbar_decode_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_dword(cfg_dword),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_is_io(cpu_is_io),
        .cpu_size(cpu_size), .pm_state(pm_state), .io_en(io_en), .mem_en(mem_en),
        .dev_off(dev_off), .gfx_dis(gfx_dis), .cpu_claim(cpu_claim)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dword = idx; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_dword = idx;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic cpu_cycle(input logic [31:0] a, input logic io, input logic [1:0] sz,
                             output logic clm);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_is_io = io; cpu_size = sz;
        @(negedge clk);
        cpu_valid = 1'b0;
        clm = cpu_claim;
        @(negedge clk);
        check("claim lasts one cycle R6", {31'd0, cpu_claim}, 32'd0);
    endtask

    task automatic io_gates_on();
        pm_state = 2'b00; io_en = 1'b1; dev_off = 1'b0; gfx_dis = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic c;
        cfg_read(MEM_IDX, d);   check("R1 mem reset", d, 32'h0000_0000);
        cfg_read(IO_IDX, d);    check("R1 io reset", d, 32'h0000_0001);
        cpu_cycle(32'h0000_0000, 1'b0, 2'b10, c);
        check("R11 zero base no claim when mem_en=0", {31'd0, c}, 32'd0);
    endtask

    task automatic t_mem_bar();
        logic [31:0] d;
        cfg_write(MEM_IDX, 4'hF, 32'hFFFF_FFFF);
        cfg_read(MEM_IDX, d);   check("R2 mem all ones", d, 32'hFFF8_0000);
        cfg_write(MEM_IDX, 4'hF, 32'h1234_5678);
        cfg_read(MEM_IDX, d);   check("R2 mem pattern", d, 32'h1230_0000);
    endtask

    task automatic t_io_bar();
        logic [31:0] d;
        cfg_write(IO_IDX, 4'hF, 32'hFFFF_FFFF);
        cfg_read(IO_IDX, d);    check("R3 io all ones", d, 32'h0000_FFF9);
        cfg_write(IO_IDX, 4'hF, 32'h0000_0000);
        cfg_read(IO_IDX, d);    check("R3 io zeros keeps bit0", d, 32'h0000_0001);
    endtask

    task automatic t_byte_en();
        logic [31:0] d;
        cfg_write(MEM_IDX, 4'hF, 32'h0000_0000);
        cfg_write(MEM_IDX, 4'b1000, 32'hAAFF_FFFF);
        cfg_read(MEM_IDX, d);   check("R4 mem byte3 only", d, 32'hAA00_0000);
        cfg_write(MEM_IDX, 4'b0100, 32'h55FF_FFFF);
        cfg_read(MEM_IDX, d);   check("R4 mem byte2 only", d, 32'hAAF8_0000);
        cfg_write(IO_IDX, 4'b0001, 32'hFFFF_FFFF);
        cfg_read(IO_IDX, d);    check("R4 io byte0 only", d, 32'h0000_00F9);
        cfg_write(IO_IDX, 4'b0000, 32'h0000_0000);
        cfg_read(IO_IDX, d);    check("R4 no lanes no change", d, 32'h0000_00F9);
    endtask

    task automatic t_other_idx();
        logic [31:0] d;
        cfg_write(6'd7, 4'hF, 32'h0000_0000);
        cfg_write(6'd4, 4'hF, 32'h0000_0000);
        cfg_read(6'd7, d);      check("R5 other index reads zero", d, 32'h0);
        cfg_read(MEM_IDX, d);   check("R5 mem untouched", d, 32'hAAF8_0000);
        cfg_read(IO_IDX, d);    check("R5 io untouched", d, 32'h0000_00F9);
        repeat (3) @(negedge clk);
        check("R5 rdata holds", cfg_rdata, 32'h0000_00F9);
    endtask

    task automatic t_mem_claim();
        logic c;
        cfg_write(MEM_IDX, 4'hF, 32'h1000_0000);
        cpu_cycle(32'h1000_0000, 1'b0, 2'b10, c);
        check("R11 mem_en=0 blocks", {31'd0, c}, 32'd0);
        mem_en = 1'b1;
        cpu_cycle(32'h1000_0000, 1'b0, 2'b10, c); check("R6 base hit", {31'd0, c}, 32'd1);
        cpu_cycle(32'h1007_FFFC, 1'b0, 2'b10, c); check("R6 top of window", {31'd0, c}, 32'd1);
        cpu_cycle(32'h1008_0000, 1'b0, 2'b10, c); check("R6 just past", {31'd0, c}, 32'd0);
        cpu_cycle(32'h0FFF_FFFF, 1'b0, 2'b00, c); check("R6 just below", {31'd0, c}, 32'd0);
        cpu_cycle(32'h1000_0000, 1'b1, 2'b00, c); check("R6 io type misses mem", {31'd0, c}, 32'd0);
    endtask

    task automatic t_io_gate();
        logic c;
        cfg_write(IO_IDX, 4'hF, 32'h0000_3CF8);
        io_gates_on();
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R7 io hit", {31'd0, c}, 32'd1);
        cpu_cycle(32'h0000_3CFF, 1'b1, 2'b00, c); check("R7 io last byte", {31'd0, c}, 32'd1);
        cpu_cycle(32'h0000_3D00, 1'b1, 2'b00, c); check("R7 io past", {31'd0, c}, 32'd0);
        cpu_cycle(32'h0001_3CF8, 1'b1, 2'b00, c); check("R7 upper bits set", {31'd0, c}, 32'd0);
        cpu_cycle(32'h0000_3CF8, 1'b0, 2'b00, c); check("R7 mem type misses io", {31'd0, c}, 32'd0);
        for (int p = 1; p < 4; p++) begin
            pm_state = 2'(p);
            cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R8 low power", {31'd0, c}, 32'd0);
        end
        io_gates_on(); io_en = 1'b0;
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R8 io_en=0", {31'd0, c}, 32'd0);
        io_gates_on(); dev_off = 1'b1;
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R8 dev_off", {31'd0, c}, 32'd0);
        io_gates_on(); gfx_dis = 1'b1;
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R8 gfx_dis", {31'd0, c}, 32'd0);
        io_gates_on(); mem_en = 1'b0;
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b00, c); check("R7 io ignores mem_en", {31'd0, c}, 32'd1);
        mem_en = 1'b1;
    endtask

    task automatic t_sizes();
        logic c;
        io_gates_on();
        cpu_cycle(32'h0000_3CFA, 1'b1, 2'b01, c); check("R9 word", {31'd0, c}, 32'd1);
        cpu_cycle(32'h0000_3CFC, 1'b1, 2'b10, c); check("R9 dword", {31'd0, c}, 32'd1);
        cpu_cycle(32'h0000_3CFE, 1'b1, 2'b10, c); check("R9 dword spills past end", {31'd0, c}, 32'd1);
        cpu_cycle(32'h0000_3CF8, 1'b1, 2'b11, c); check("R9 reserved io", {31'd0, c}, 32'd0);
        cpu_cycle(32'h1000_0000, 1'b0, 2'b11, c); check("R9 reserved mem", {31'd0, c}, 32'd0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dword = MEM_IDX; cfg_be = 4'hF; cfg_wdata = 32'h2000_0000;
        cpu_valid = 1'b1; cpu_addr = 32'h2000_0000; cpu_is_io = 1'b0; cpu_size = 2'b10;
        @(negedge clk);
        cfg_wr_en = 1'b0; cpu_valid = 1'b0;
        check("R10 new base not yet used", {31'd0, cpu_claim}, 32'd0);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wdata = 32'h3000_0000;
        cpu_valid = 1'b1; cpu_addr = 32'h2000_0000;
        @(negedge clk);
        cfg_wr_en = 1'b0; cpu_valid = 1'b0;
        check("R10 old base still claims", {31'd0, cpu_claim}, 32'd1);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 32'h3000_0000;
        @(negedge clk);
        cpu_valid = 1'b0;
        check("R10 new base next cycle", {31'd0, cpu_claim}, 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mem_bar();
        t_io_bar();
        t_byte_en();
        t_other_idx();
        t_mem_claim();
        t_io_gate();
        t_sizes();
        t_same_cycle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule